// File: doc/BRIEF.md
# Configuration Clock Burst Generator

This block lets a bus master emit an exact, software-chosen number of configuration clock pulses on a single output pin. A small memory-mapped slave with 32-bit data and addresses holds two registers. Writing the pulse-count register launches a one-shot train of that many clock periods. When the last period ends, a sticky completion flag rises and stays set until software writes a one to it.

The clock is a registered output. Each half period lasts `HALF_DIV` system clocks, so the high and low phases are always equal. Software typically clears the flag, writes a count such as 256 (to flush a configuration port) or 2047 (before streaming data), polls the flag, and clears it again. Any legal count finishes in `2*count*HALF_DIV` cycles. A zero count completes at once with no pulse. A count write that lands while a train is running is dropped.

Top module: `cbg_dclk_burst`

## Requirements
- R1: After reset, the status register reads 0, the count register reads 0 and `dclk_o` is low.
- R2: A write of a nonzero value N to byte offset 0x08 while idle produces exactly N rising edges on `dclk_o`. Status bit 1 (busy) reads 1 from the cycle after the write until the train ends. Status bit 0 (done) becomes 1, and busy returns to 0, on the clock edge 2*N*HALF_DIV cycles after the write edge.
- R3: Status lives at byte offset 0x0C, with done in bit 0. Writing there with bit 0 set clears done. Writing there with bit 0 clear leaves done unchanged. When a set and a clear fall on the same edge, the set wins.
- R4: A write to offset 0x08 while busy is ignored: the count readback and the number of pulses are both unaffected.
- R5: A write of 0 to offset 0x08 while idle sets done on that write edge, emits no pulse and leaves busy at 0.
- R6: During a train, `dclk_o` is low for HALF_DIV cycles after the write edge, then alternates high and low in phases of exactly HALF_DIV cycles. The train ends low, and `dclk_o` stays low while idle.
- R7: Offset 0x08 reads back the last accepted count in its low CNT_W bits, with all upper bits 0.
- R8: Any offset other than 0x08 and 0x0C reads as 0 and ignores writes: no train starts and neither register changes.
- R9: The counts 256 and 2047 run to completion with exact pulse counts. The count field is at least 11 bits wide, and this is checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| dclk_o | output | 1 | Generated configuration clock |

## Verification
The write edge is taken as cycle 0. Busy and the zero-count done are due one cycle later. The first rising edge of `dclk_o` is due HALF_DIV cycles after the write edge, and done together with busy-clear is due 2*N*HALF_DIV cycles after it. Every check samples on the falling system clock edge after a counted number of cycles. Each burst is probed one cycle before its due point (done still 0, busy still 1) and at the due point. The waveform test compares `dclk_o` against the expected phase pattern in every cycle of a train. Reads are combinational, so a status peek never shifts this cycle count.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
   localparam int unsigned BUS_W = 32;
   localparam logic [BUS_W-1:0] OFS_COUNT  = 32'h0000_0008;
   localparam logic [BUS_W-1:0] OFS_STATUS = 32'h0000_000C;
   localparam int unsigned ST_DONE_BIT = 0;
   localparam int unsigned ST_BUSY_BIT = 1;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_COUNT  = 2'd1,
      SEL_STATUS = 2'd2
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [BUS_W-1:0] a);
      if (a == OFS_COUNT)       return SEL_COUNT;
      else if (a == OFS_STATUS) return SEL_STATUS;
      else                      return SEL_NONE;
   endfunction
endpackage

// File: rtl/cbg_phase_tick.sv
module cbg_phase_tick #(
   parameter int unsigned HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   generate
      if (HALF_DIV < 1) begin : g_bad
         $error("cbg_phase_tick: HALF_DIV must be at least 1");
      end
      if (HALF_DIV == 1) begin : g_direct
         assign tick_o = run_i;
      end else begin : g_count
         localparam int unsigned PH_W = $clog2(HALF_DIV);
         localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_DIV - 1);
         logic [PH_W-1:0] phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                phase_q <= '0;
            else if (!run_i)           phase_q <= '0;
            else if (phase_q == PH_LAST) phase_q <= '0;
            else                       phase_q <= phase_q + 1'b1;
         end
         assign tick_o = run_i && (phase_q == PH_LAST);

         a_r6_phase_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            phase_q <= PH_LAST);
      end
   endgenerate
endmodule

// File: rtl/cbg_pulse_ctrl.sv
module cbg_pulse_ctrl #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             tick_i,
   output logic             busy_o,
   output logic             finish_o,
   output logic             dclk_o
);
   logic [CNT_W-1:0] left_q;
   logic             busy_q;
   logic             dclk_q;
   logic             fall_now;

   assign fall_now = busy_q && tick_i && dclk_q;
   assign finish_o = fall_now && (left_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         busy_q <= 1'b0;
         dclk_q <= 1'b0;
      end else if (start_i) begin
         left_q <= count_i;
         busy_q <= 1'b1;
         dclk_q <= 1'b0;
      end else if (busy_q && tick_i) begin
         dclk_q <= ~dclk_q;
         if (dclk_q) begin
            left_q <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) busy_q <= 1'b0;
         end
      end
   end

   assign busy_o = busy_q;
   assign dclk_o = dclk_q;

   a_r6_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !dclk_q);
   a_r6_toggle_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dclk_q) |-> $past(tick_i));
   a_r4_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_q);
   a_r2_finish_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      finish_o |=> (!busy_q && !dclk_q));
   a_r2_nonzero_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (left_q != '0));
endmodule

// File: rtl/cbg_regs.sv
module cbg_regs
   import cbg_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [BUS_W-1:0] bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic             busy_i,
   input  logic             finish_i,
   output logic             start_o,
   output logic [CNT_W-1:0] count_o
);
   reg_sel_e         sel;
   logic             wr_count, wr_status;
   logic             accept, zero_done, set_done, clr_done;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] wcount;
   logic             done_q;

   assign sel       = decode_ofs(bus_addr);
   assign wr_count  = bus_sel && bus_wr && (sel == SEL_COUNT);
   assign wr_status = bus_sel && bus_wr && (sel == SEL_STATUS);
   assign wcount    = bus_wdata[CNT_W-1:0];
   assign accept    = wr_count && !busy_i;
   assign zero_done = accept && (wcount == '0);
   assign start_o   = accept && (wcount != '0);
   assign count_o   = wcount;
   assign set_done  = finish_i || zero_done;
   assign clr_done  = wr_status && bus_wdata[ST_DONE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count_q <= '0;
      else if (accept) count_q <= wcount;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        done_q <= 1'b0;
      else if (set_done) done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         unique case (sel)
            SEL_COUNT:  bus_rdata[CNT_W-1:0] = count_q;
            SEL_STATUS: begin
               bus_rdata[ST_DONE_BIT] = done_q;
               bus_rdata[ST_BUSY_BIT] = busy_i;
            end
            default:    bus_rdata = '0;
         endcase
      end
   end

   a_r4_count_holds_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_count && busy_i) |=> $stable(count_q));
   a_r3_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_done && !finish_i && !zero_done) |=> !done_q);
   a_r2_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(finish_i || zero_done));
   a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && sel == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: rtl/cbg_dclk_burst.sv
module cbg_dclk_burst
   import cbg_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned HALF_DIV = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [31:0] bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        dclk_o
);
   generate
      if (CNT_W < 11 || CNT_W > BUS_W) begin : g_bad_cnt
         $error("cbg_dclk_burst: CNT_W must lie in 11..32");
      end
   endgenerate

   logic             start, busy, finish, tick;
   logic [CNT_W-1:0] load_count;

   cbg_regs #(.CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .busy_i   (busy),
      .finish_i (finish),
      .start_o  (start),
      .count_o  (load_count)
   );

   cbg_phase_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (busy),
      .tick_o(tick)
   );

   cbg_pulse_ctrl #(.CNT_W(CNT_W)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .count_i (load_count),
      .tick_i  (tick),
      .busy_o  (busy),
      .finish_o(finish),
      .dclk_o  (dclk_o)
   );
endmodule

// File: tb/sim_cbg_dclk_burst.sv
`timescale 1ns/1ps
module sim_cbg_dclk_burst;
   localparam int H = 2;
   localparam int CW = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [31:0] bus_addr = '0, bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        dclk_o;

   int checks = 0;
   int failures = 0;
   int pulses = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   cbg_dclk_burst #(.CNT_W(CW), .HALF_DIV(H)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dclk_o(dclk_o)
   );

   always @(posedge dclk_o) pulses++;

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic clear_done();
      bus_write(32'h0C, 32'h1);
   endtask

   // Run a full burst and check the R2 timing at the due edge.
   task automatic run_burst(input string req, input int n);
      logic [31:0] st;
      clear_done();
      pulses = 0;
      bus_write(32'h08, n);
      bus_read(32'h0C, st);
      chk({req, " busy after start"}, st[1], 1);
      repeat (2*n*H - 1) @(negedge clk);
      bus_read(32'h0C, st);
      chk({req, " one cycle early: done=0 busy=1"}, st[1:0], 2'b10);
      @(negedge clk);
      bus_read(32'h0C, st);
      chk({req, " at due edge: done=1 busy=0"}, st[1:0], 2'b01);
      chk({req, " pulse count"}, pulses, n);
      chk({req, " dclk low at end"}, dclk_o, 0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      bus_read(32'h0C, d); chk("R1 status after reset", d, 0);
      bus_read(32'h08, d); chk("R1 count after reset", d, 0);
      chk("R1 dclk after reset", dclk_o, 0);
   endtask

   task automatic t_basic();
      logic [31:0] d;
      run_burst("R2 n=5", 5);
      bus_read(32'h08, d); chk("R7 count readback", d, 5);
      run_burst("R2 n=1", 1);
   endtask

   task automatic t_waveform();
      int n = 3;
      bit ok = 1;
      clear_done();
      bus_write(32'h08, n);
      for (int m = 0; m < 2*n*H; m++) begin
         if (dclk_o !== 1'(((m / H) % 2))) begin
            ok = 0;
            $display("FAIL R6 waveform at cycle %0d actual=%0b expected=%0b",
                     m, dclk_o, ((m / H) % 2));
         end
         @(negedge clk);
      end
      chk("R6 waveform phases", ok, 1);
      chk("R6 low after train", dclk_o, 0);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      bus_read(32'h0C, d); chk("R3 done set before clear test", d[0], 1);
      bus_write(32'h0C, 32'hFFFF_FFFE);
      bus_read(32'h0C, d); chk("R3 write of 0 keeps done", d[0], 1);
      bus_write(32'h0C, 32'h1);
      bus_read(32'h0C, d); chk("R3 write of 1 clears done", d[0], 0);
   endtask

   task automatic t_zero();
      logic [31:0] d;
      clear_done();
      pulses = 0;
      bus_write(32'h08, 0);
      bus_read(32'h0C, d); chk("R5 zero count: done=1 busy=0", d[1:0], 2'b01);
      repeat (8) @(negedge clk);
      chk("R5 zero count: no pulse", pulses, 0);
      bus_read(32'h08, d); chk("R5 zero count readback", d, 0);
   endtask

   task automatic t_busy_write();
      logic [31:0] d;
      clear_done();
      pulses = 0;
      bus_write(32'h08, 4);
      bus_write(32'h08, 9);
      bus_read(32'h08, d); chk("R4 count unchanged by busy write", d, 4);
      repeat (2*4*H - 2) @(negedge clk);
      bus_read(32'h0C, d); chk("R4 done on original schedule", d[1:0], 2'b01);
      repeat (60) @(negedge clk);
      chk("R4 pulse count unchanged", pulses, 4);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      clear_done();
      pulses = 0;
      bus_write(32'h10, 32'h7);
      bus_write(32'h04, 32'h7);
      bus_write(32'h09, 32'h7);
      repeat (10) @(negedge clk);
      chk("R8 no pulses from unmapped writes", pulses, 0);
      bus_read(32'h0C, d); chk("R8 status untouched", d, 0);
      bus_read(32'h08, d); chk("R8 count untouched", d, 0);
      bus_read(32'h10, d); chk("R8 unmapped read 0x10", d, 0);
      bus_read(32'h00, d); chk("R8 unmapped read 0x00", d, 0);
   endtask

   task automatic t_upper_bits();
      logic [31:0] d;
      clear_done();
      bus_write(32'h08, 32'hABCD_0002);
      bus_read(32'h08, d); chk("R7 upper bits dropped", d, 32'h2);
      repeat (2*2*H + 2) @(negedge clk);
   endtask

   task automatic t_set_wins();
      logic [31:0] d;
      clear_done();
      bus_write(32'h08, 1);
      // finish edge is 2*H cycles after the start edge; land a clear on it
      repeat (2*H - 2) @(negedge clk);
      bus_write(32'h0C, 32'h1);
      bus_read(32'h0C, d); chk("R3 set beats simultaneous clear", d[1:0], 2'b01);
   endtask

   initial begin
      #(150000 * 4);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unmapped();
      t_zero();
      t_basic();
      t_w1c();
      t_waveform();
      t_busy_write();
      t_upper_bits();
      t_set_wins();
      run_burst("R9 n=256", 256);
      run_burst("R9 n=2047", 2047);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule